// File: doc/BRIEF.md
# Handshaked DMA Word Sequencer

This block moves 16-bit words between a host memory bus and an attached peripheral without the processor. Software loads the negative (two's complement) number of words into the count register, loads the first memory address, and issues a start. That start drops `ready`. The peripheral then asks for each word with a one-cycle `per_req`. At that request the block captures the peripheral's control bits and its write data. It then asks the arbiter for the bus and runs one memory cycle at the current address. After the cycle it advances the count and the address.

In single-cycle mode the peripheral paces every word. In burst mode one request moves the whole block. A static configuration input chooses how a burst uses the bus. In the default burst policy the block gives up the bus after every fourth word and asks for it again. In the continuous policy the block keeps the bus until the count is used up. When the count reaches zero, `ready` rises and an interrupt request is raised if it was enabled. A memory cycle that gets no acknowledge within a fixed timeout is aborted. The block then flags a nonexistent-memory error and returns to idle.

The controller has five states:
- `ST_IDLE`: `ready` is high.
- `ST_WAIT`: the block waits for a peripheral request.
- `ST_ARB`: the bus is requested and the block waits for a grant.
- `ST_XFER`: the memory cycle runs until an acknowledge or the timeout.
- `ST_STEP`: the count and address are advanced.

The transitions are:
- start: IDLE→WAIT.
- request: WAIT→ARB.
- grant: ARB→XFER.
- acknowledge: XFER→STEP.
- timeout: XFER→IDLE.
- last word: STEP→IDLE.
- single-cycle: STEP→WAIT.
- burst with the bus kept: STEP→XFER.
- burst with the bus released: STEP→ARB.

Top module: `dma_word_sequencer`

## Requirements
- R1: After reset:
  - `ready` and `per_idle` are 1.
  - `bus_req`, `mem_cyc`, `irq` and `nxm` are 0.
  - `word_count` and `mem_addr` are 0.
- R2: `sw_start` is accepted only while `ready` is 1. It clears `irq` and `nxm`. From the next cycle `ready` stays 0 until the transfer ends, including the gaps between single-cycle words.
- R3: On a cycle with `per_req` high while waiting:
  - the control inputs (`per_cnt_en`, `per_adr_en`, `per_to_mem`, `per_single`) are captured;
  - `per_data_in` is captured as the write data;
  - `per_idle` goes to 0 on the next cycle.
- R4: `mem_cyc` is high only while `bus_req` is high, and only after `bus_grant` has been seen. Memory is written when `mem_write` is 1 (captured `per_to_mem`=1) and read when it is 0.
- R5: Each acknowledged word does two things:
  - it adds 1 to `word_count` if the captured count enable was 1;
  - it adds 2 to `mem_addr` if the captured address enable was 1.
- R6: When the count steps to zero:
  - `ready` returns to 1 on the next cycle;
  - `irq` is set if `sw_irq_en` is 1 at that step, and stays 0 otherwise.
- R7: For a memory read, `mem_rdata` present with `mem_ack` is held on `per_data_out`.
- R8: With captured `per_single`=1, `per_idle` returns to 1 after each word, and the next word waits for a new `per_req`.
- R9: With captured `per_single`=0 and `cfg_hold_bus`=0, one request transfers the whole block. `bus_req` drops for exactly one cycle after every fourth word.
- R10: With captured `per_single`=0 and `cfg_hold_bus`=1, `bus_req` stays high from the first grant until the last word.
- R11: With `cfg_wide`=0, loaded and stepped addresses keep only their low 18 bits, so stepping wraps to 0. With `cfg_wide`=1 all 22 bits are used.
- R12: If `mem_ack` does not arrive within `ACK_TMO` cycles of `mem_cyc`:
  - the cycle is abandoned;
  - `nxm` is set;
  - `ready` returns to 1;
  - count and address are left unchanged.
- R13: `sw_load_count` and `sw_load_addr` have no effect while `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 selects a 22-bit address, 0 selects an 18-bit address |
| cfg_hold_bus | input | 1 | 1 keeps the bus for the whole burst, 0 releases it every four words |
| sw_load_count | input | 1 | Load `sw_count_val` into the count |
| sw_count_val | input | 16 | Negative word count |
| sw_load_addr | input | 1 | Load `sw_addr_val` into the address |
| sw_addr_val | input | 22 | Start address |
| sw_start | input | 1 | Begin a transfer block |
| sw_irq_en | input | 1 | Interrupt enable |
| per_req | input | 1 | Peripheral cycle request |
| per_cnt_en | input | 1 | Count-advance enable |
| per_adr_en | input | 1 | Address-advance enable |
| per_to_mem | input | 1 | 1 writes memory, 0 reads memory |
| per_single | input | 1 | 1 selects single-cycle, 0 selects burst |
| per_data_in | input | 16 | Peripheral write data |
| per_data_out | output | 16 | Last word read from memory |
| per_idle | output | 1 | High when no word is in progress |
| ready | output | 1 | High when the block is idle |
| irq | output | 1 | Interrupt request |
| nxm | output | 1 | Nonexistent-memory error |
| word_count | output | 16 | Current count |
| bus_req | output | 1 | Bus mastership request |
| bus_grant | input | 1 | Bus mastership grant |
| mem_cyc | output | 1 | Memory cycle active |
| mem_write | output | 1 | Memory cycle is a write |
| mem_addr | output | 22 | Current address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ack | input | 1 | Memory cycle acknowledge |

## Verification
The assertions check four relations on every cycle:
- a memory cycle never runs without the bus request;
- the peripheral is never shown busy while the block is ready;
- an error or an interrupt only appears together with `ready`;
- the upper address bits stay clear in 18-bit mode.

The following can only be shown by the bench scenarios, which compare a behavioural model on every clock:
- the count and address arithmetic;
- the single bus release after every fourth burst word;
- the continuous hold of the bus;
- the timeout path;
- loads being ignored during a transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ARB,
        ST_XFER,
        ST_STEP
    } seq_state_t;
endpackage

// File: rtl/dma_cnt_addr.sv
module dma_cnt_addr #(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 22,
    parameter int NARROW_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              load_cnt,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              load_adr,
    input  logic [ADDR_W-1:0] adr_val,
    input  logic              step,
    input  logic              cnt_en,
    input  logic              adr_en,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] addr,
    output logic              cnt_last
);
    localparam logic [ADDR_W-1:0] NARROW_MASK =
        {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] mask;
    assign mask     = wide ? {ADDR_W{1'b1}} : NARROW_MASK;
    assign cnt_last = &cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            addr <= '0;
        end else begin
            if (load_cnt)
                cnt <= cnt_val;
            else if (step && cnt_en)
                cnt <= cnt + CNT_W'(1);
            if (load_adr)
                addr <= adr_val & mask;
            else if (step && adr_en)
                addr <= (addr + WORD_STEP) & mask;
        end
    end
endmodule

// File: rtl/dma_ack_timer.sv
module dma_ack_timer #(
    parameter int TMO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(TMO + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TMO - 1);

    logic [TW-1:0] ticks;
    assign expire = run && (ticks == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ticks <= '0;
        else if (!run)
            ticks <= '0;
        else if (ticks != LIMIT)
            ticks <= ticks + TW'(1);
    end
endmodule

// File: rtl/dma_word_sequencer.sv
module dma_word_sequencer
    import dma_seq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 22,
    parameter int NARROW_W = 18,
    parameter int ACK_TMO  = 8,
    parameter int GROUP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_hold_bus,
    input  logic              sw_load_count,
    input  logic [CNT_W-1:0]  sw_count_val,
    input  logic              sw_load_addr,
    input  logic [ADDR_W-1:0] sw_addr_val,
    input  logic              sw_start,
    input  logic              sw_irq_en,
    input  logic              per_req,
    input  logic              per_cnt_en,
    input  logic              per_adr_en,
    input  logic              per_to_mem,
    input  logic              per_single,
    input  logic [DATA_W-1:0] per_data_in,
    output logic [DATA_W-1:0] per_data_out,
    output logic              per_idle,
    output logic              ready,
    output logic              irq,
    output logic              nxm,
    output logic [CNT_W-1:0]  word_count,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              mem_cyc,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam logic [GROUP_W-1:0] GROUP_END = {GROUP_W{1'b1}};

    seq_state_t        state, nxt;
    logic              cap_cnt_en, cap_adr_en, cap_wr, cap_single;
    logic [GROUP_W-1:0] grp;
    logic [DATA_W-1:0] in_buf, out_buf;
    logic              irq_q, nxm_q;
    logic              cnt_last, expire;
    logic              is_idle, is_step, last, burst, keep;

    assign is_idle = (state == ST_IDLE);
    assign is_step = (state == ST_STEP);
    assign last    = cap_cnt_en && cnt_last;
    assign burst   = !cap_single;
    assign keep    = cfg_hold_bus || (grp != GROUP_END);

    dma_cnt_addr #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .NARROW_W(NARROW_W)
    ) u_cnt_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (cfg_wide),
        .load_cnt (sw_load_count && is_idle),
        .cnt_val  (sw_count_val),
        .load_adr (sw_load_addr && is_idle),
        .adr_val  (sw_addr_val),
        .step     (is_step),
        .cnt_en   (cap_cnt_en),
        .adr_en   (cap_adr_en),
        .cnt      (word_count),
        .addr     (mem_addr),
        .cnt_last (cnt_last)
    );

    dma_ack_timer #(.TMO(ACK_TMO)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_XFER),
        .expire (expire)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (sw_start) nxt = ST_WAIT;
            ST_WAIT: if (per_req) nxt = ST_ARB;
            ST_ARB:  if (bus_grant) nxt = ST_XFER;
            ST_XFER: begin
                if (mem_ack)     nxt = ST_STEP;
                else if (expire) nxt = ST_IDLE;
            end
            ST_STEP: begin
                if (last)        nxt = ST_IDLE;
                else if (!burst) nxt = ST_WAIT;
                else if (keep)   nxt = ST_XFER;
                else             nxt = ST_ARB;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_cnt_en <= 1'b0;
            cap_adr_en <= 1'b0;
            cap_wr     <= 1'b0;
            cap_single <= 1'b1;
            grp        <= '0;
            in_buf     <= '0;
            out_buf    <= '0;
            irq_q      <= 1'b0;
            nxm_q      <= 1'b0;
        end else begin
            if (state == ST_WAIT && per_req) begin
                cap_cnt_en <= per_cnt_en;
                cap_adr_en <= per_adr_en;
                cap_wr     <= per_to_mem;
                cap_single <= per_single;
                in_buf     <= per_data_in;
                grp        <= '0;
            end
            if (is_step) begin
                grp <= grp + GROUP_W'(1);
                if (!last && burst) in_buf <= per_data_in;
            end
            if (state == ST_XFER && mem_ack && !cap_wr)
                out_buf <= mem_rdata;
            if (is_idle && sw_start) begin
                irq_q <= 1'b0;
                nxm_q <= 1'b0;
            end else begin
                if (is_step && last && sw_irq_en) irq_q <= 1'b1;
                if (state == ST_XFER && !mem_ack && expire) nxm_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ready        = is_idle;
        per_idle     = is_idle || (state == ST_WAIT);
        mem_cyc      = (state == ST_XFER);
        mem_write    = (state == ST_XFER) && cap_wr;
        bus_req      = (state == ST_ARB) || (state == ST_XFER) ||
                       (is_step && !last && burst && keep);
        mem_wdata    = in_buf;
        per_data_out = out_buf;
        irq          = irq_q;
        nxm          = nxm_q;
    end
endmodule

// File: rtl/dma_seq_checker.sv
module dma_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wide,
    input logic        ready,
    input logic        per_idle,
    input logic        bus_req,
    input logic        mem_cyc,
    input logic        irq,
    input logic        nxm,
    input logic [21:0] mem_addr
);
    // R4
    cyc_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |-> bus_req);
    // R3
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !per_idle |-> !ready);
    // R12
    nxm_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nxm) |-> ready);
    // R6
    irq_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ready);
    // R11
    narrow_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wide && $stable(cfg_wide) && !$rose(ready)) |-> (mem_addr[21:18] == 4'd0 || $changed(mem_addr) == 1'b0));
endmodule

bind dma_word_sequencer dma_seq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wide (cfg_wide),
    .ready    (ready),
    .per_idle (per_idle),
    .bus_req  (bus_req),
    .mem_cyc  (mem_cyc),
    .irq      (irq),
    .nxm      (nxm),
    .mem_addr (mem_addr)
);

// File: tb/dma_word_sequencer_test.sv
module dma_word_sequencer_test;
    localparam int TMO = 8;

    logic clk = 0, rst_n = 0;
    logic cfg_wide = 1, cfg_hold_bus = 0;
    logic sw_load_count = 0, sw_load_addr = 0, sw_start = 0, sw_irq_en = 0;
    logic [15:0] sw_count_val = 0;
    logic [21:0] sw_addr_val = 0;
    logic per_req = 0, per_cnt_en = 1, per_adr_en = 1, per_to_mem = 1, per_single = 1;
    logic [15:0] per_data_in = 0;
    logic [15:0] per_data_out, mem_wdata, mem_rdata, word_count;
    logic per_idle, ready, irq, nxm, bus_req, mem_cyc, mem_write;
    logic [21:0] mem_addr;
    logic bus_grant = 0, mem_ack = 0, ack_en = 1;
    logic [15:0] mem [0:63];
    int checks = 0, fails = 0, drops = 0, cyc_wo_req = 0;
    logic prev_req = 0;

    always #5 clk = ~clk;

    dma_word_sequencer #(.ACK_TMO(TMO)) uut (.*);

    assign mem_rdata = mem[mem_addr[6:1]];
    always @(posedge clk) begin
        bus_grant <= bus_req;
        mem_ack   <= mem_cyc && !mem_ack && ack_en;
        if (mem_cyc && mem_write && mem_ack) mem[mem_addr[6:1]] <= mem_wdata;
    end

    // behavioural reference: 0 idle,1 wait,2 arb,3 xfer,4 step
    int ms, mg, mt;
    logic [15:0] mc, mib, mob;
    logic [21:0] ma;
    logic mcen, maen, mwr, msing, mirq, mnxm;
    function automatic logic [21:0] msk(input logic [21:0] a, input logic w);
        return w ? a : (a & 22'h3FFFF);
    endfunction
    function automatic logic mlast();
        return mcen && (mc == 16'hFFFF);
    endfunction
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mg = 0; mt = 0; mc = 0; ma = 0; mib = 0; mob = 0;
            mcen = 0; maen = 0; mwr = 0; msing = 1; mirq = 0; mnxm = 0;
        end else begin
            case (ms)
                0: begin
                    if (sw_load_count) mc = sw_count_val;
                    if (sw_load_addr) ma = msk(sw_addr_val, cfg_wide);
                    if (sw_start) begin mirq = 0; mnxm = 0; ms = 1; end
                end
                1: if (per_req) begin
                    mcen = per_cnt_en; maen = per_adr_en; mwr = per_to_mem;
                    msing = per_single; mib = per_data_in; mg = 0; ms = 2;
                end
                2: if (bus_grant) begin ms = 3; mt = 0; end
                3: if (mem_ack) begin
                    if (!mwr) mob = mem_rdata;
                    ms = 4;
                end else if (mt == TMO - 1) begin
                    mnxm = 1; ms = 0;
                end else mt++;
                default: begin
                    automatic logic l = mlast();
                    automatic int g = mg;
                    if (mcen) mc = mc + 1;
                    if (maen) ma = msk(ma + 22'd2, cfg_wide);
                    mg = (mg + 1) % 4;
                    mt = 0;
                    if (l) begin if (sw_irq_en) mirq = 1; ms = 0; end
                    else if (msing) ms = 1;
                    else begin
                        mib = per_data_in;
                        ms = (cfg_hold_bus || g != 3) ? 3 : 2;
                    end
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            automatic logic ebr = (ms == 2) || (ms == 3) ||
                (ms == 4 && !mlast() && !msing && (cfg_hold_bus || mg != 3));
            automatic logic [31:0] a, e;
            a = {ready, per_idle, bus_req, mem_cyc, mem_write, irq, nxm};
            e = {ms == 0, ms <= 1, ebr, ms == 3, ms == 3 && mwr, mirq, mnxm};
            chk("R2/R3/R4/R6/R8/R9/R10/R12 ctrl", a, e);
            chk("R5/R11/R13 cnt+addr", {mem_addr, word_count[9:0]}, {ma, mc[9:0]});
            chk("R5 count hi", word_count, mc);
            chk("R3/R7 data", {per_data_out, mem_wdata}, {mob, mib});
            if (prev_req && !bus_req) drops++;
            if (mem_cyc && !bus_req) cyc_wo_req++;
            prev_req = bus_req;
        end
    end

    task automatic setup(input logic [15:0] c, input logic [21:0] a, input logic ie);
        @(negedge clk);
        sw_count_val = c; sw_addr_val = a; sw_load_count = 1; sw_load_addr = 1;
        sw_irq_en = ie;
        @(negedge clk);
        sw_load_count = 0; sw_load_addr = 0; sw_start = 1;
        @(negedge clk);
        sw_start = 0;
    endtask

    task automatic req(input logic [15:0] d);
        @(negedge clk);
        per_data_in = d; per_req = 1;
        @(negedge clk);
        per_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (per_idle) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'hA000 + 16'(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset", {ready, per_idle, bus_req, mem_cyc, irq, nxm}, 6'b110000);
        chk("R1 reset regs", {word_count, 10'd0}, 26'd0);
        chk("R1 reset addr", mem_addr, 0);

        // single-cycle writes, irq enabled
        per_to_mem = 1; per_single = 1; per_adr_en = 1; per_cnt_en = 1;
        setup(16'hFFFD, 22'h100, 1);
        chk("R2 ready low after start", ready, 0);
        req(16'h1111); wait_idle();
        chk("R8 per_idle back high", per_idle, 1);
        chk("R2 ready low between words", ready, 0);
        req(16'h2222); wait_idle();
        req(16'h3333); wait_idle();
        chk("R5 count zero", word_count, 0);
        chk("R5 address +6", mem_addr, 22'h106);
        chk("R6 ready", ready, 1);
        chk("R6 irq", irq, 1);
        chk("R3 write data word0", mem[0], 16'h1111);
        chk("R3 write data word2", mem[2], 16'h3333);

        // reads with no address advance, irq disabled
        per_to_mem = 0; per_adr_en = 0;
        setup(16'hFFFE, 22'h8, 0);
        chk("R2 start clears irq", irq, 0);
        // R13: loads while busy ignored
        @(negedge clk);
        sw_count_val = 16'h1234; sw_addr_val = 22'h222; sw_load_count = 1; sw_load_addr = 1;
        @(negedge clk);
        sw_load_count = 0; sw_load_addr = 0;
        @(negedge clk);
        chk("R13 count unchanged", word_count, 16'hFFFE);
        chk("R13 addr unchanged", mem_addr, 22'h8);
        req(16'h0); wait_idle();
        req(16'h0); wait_idle();
        chk("R7 read data", per_data_out, 16'hA004);
        chk("R5 address held", mem_addr, 22'h8);
        chk("R6 no irq when disabled", irq, 0);

        // four-word burst policy
        per_to_mem = 1; per_adr_en = 1; per_single = 0; cfg_hold_bus = 0;
        setup(16'hFFFA, 22'h40, 0);
        drops = 0;
        req(16'h5A5A); wait_idle();
        chk("R9 one release plus end", drops, 2);
        chk("R9 count zero", word_count, 0);
        chk("R9 address", mem_addr, 22'h4C);

        // continuous burst
        cfg_hold_bus = 1;
        setup(16'hFFFA, 22'h40, 0);
        drops = 0;
        req(16'h6B6B); wait_idle();
        chk("R10 bus held", drops, 1);
        chk("R10 last word written", mem[37], 16'h6B6B);

        // timeout
        per_single = 1; ack_en = 0;
        setup(16'hFFFF, 22'h10, 1);
        req(16'h7777); wait_idle();
        chk("R12 nxm", nxm, 1);
        chk("R12 ready", ready, 1);
        chk("R12 count kept", word_count, 16'hFFFF);
        chk("R12 addr kept", mem_addr, 22'h10);
        ack_en = 1;

        // 18-bit addressing
        cfg_wide = 0;
        setup(16'hFFFF, 22'h3FFFFE, 0);
        chk("R11 narrow load", mem_addr, 22'h3FFFE);
        req(16'h1); wait_idle();
        chk("R11 narrow wrap", mem_addr, 22'h0);
        cfg_wide = 1;
        setup(16'hFFFF, 22'h3FFFFE, 0);
        chk("R11 wide load", mem_addr, 22'h3FFFFE);
        req(16'h2); wait_idle();
        chk("R4 no cycle without request", cyc_wo_req, 0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule